// File: doc/BRIEF.md
# Four-Value Completeness Gate Network

This block provides two-input logic gates that work over a four-value domain carried on two bits per signal: NULL, Intermediate, and the two Boolean data values. A gate gives a data result only once both operands carry data, and it gives NULL only once both operands have returned to NULL. Every other operand pair gives Intermediate. Each gate therefore waits for a complete set of inputs before it shows a result, both when data arrives and when the network is cleared back to NULL. A single input that drops to NULL cannot pull an output to NULL while data still sits elsewhere in the network.

The top level is a small example network built from these gates. It contains one gate of each Boolean flavour on operands `in_a` and `in_b`, a full adder over `in_a`, `in_b` and `in_c`, and a final AND of the carry with `in_d`. A completion detector watches all six results. It raises one flag when every result holds data and another when every result is NULL. It ignores the Intermediate values in between. A user presents a data set, waits for the data flag, returns every input to NULL, and waits for the NULL flag before presenting the next set.

Top module: `q4_cell_net`

## Requirements
- R1: Codes are 2'b00 NULL, 2'b01 Intermediate, 2'b10 data FALSE and 2'b11 data TRUE. When both operands are data, `out_and`, `out_or` and `out_xor` give the data code of the AND, OR and XOR of the two operand truth values.
- R2: When both operands are NULL, each gate output is NULL (2'b00).
- R3: When one operand is NULL and the other is data, the gate output is Intermediate (2'b01), never NULL or data.
- R4: When either operand is Intermediate, the gate output is Intermediate.
- R5: When `in_a`, `in_b`, `in_c` and `in_d` all carry data, `out_sum` is the XOR of a, b and c, and `out_carry` is their majority. `out_gated` is the carry ANDed with d.
- R6: When all four inputs are NULL, all six result outputs are NULL, `set_null` is 1 and `set_data` is 0.
- R7: While any input holds data, `out_gated` is not NULL and `set_null` is 0. While any input is NULL, `out_gated` is not data and `set_data` is 0.
- R8: `set_data` is 1 exactly when all six result outputs hold data. `set_null` is 1 exactly when all six are NULL. Both are 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | 2 | First operand, four-value code |
| in_b | input | 2 | Second operand, four-value code |
| in_c | input | 2 | Adder carry-in operand |
| in_d | input | 2 | Enable operand for the gated carry |
| out_and | output | 2 | AND gate of in_a and in_b |
| out_or | output | 2 | OR gate of in_a and in_b |
| out_xor | output | 2 | XOR gate of in_a and in_b |
| out_sum | output | 2 | Full-adder sum of in_a, in_b, in_c |
| out_carry | output | 2 | Full-adder carry of in_a, in_b, in_c |
| out_gated | output | 2 | out_carry ANDed with in_d |
| set_data | output | 1 | All six results hold data |
| set_null | output | 1 | All six results are NULL |

## Verification
The block has no registers, so every result and both flags are due in the same cycle as the input change that causes them, once the combinational paths have settled. The bench changes the inputs just after a rising clock edge and samples at the following falling edge. That gives a half period of settling and keeps each sample clear of the edge. The wavefront tests change one input per cycle and check every intermediate step, so an early NULL or an early data result shows up in the exact cycle where it appears.

// File: rtl/q4_pkg.sv
// Shared definitions for the four-value completeness logic.
// Assumes the two-bit code: bit 1 marks data, bit 0 is the truth value
// for data and separates NULL from Intermediate otherwise.
package q4_pkg;

    typedef logic [1:0] q4_t;

    localparam q4_t Q4_NULL  = 2'b00;
    localparam q4_t Q4_MID   = 2'b01;
    localparam q4_t Q4_FALSE = 2'b10;
    localparam q4_t Q4_TRUE  = 2'b11;

    typedef enum logic [1:0] {
        FN_AND = 2'd0,
        FN_OR  = 2'd1,
        FN_XOR = 2'd2
    } q4_fn_e;

    // True when the code carries a data value
    function automatic logic q4_is_data(input q4_t v);
        return v[1];
    endfunction

    // True when the code is NULL
    function automatic logic q4_is_null(input q4_t v);
        return v == Q4_NULL;
    endfunction

endpackage

// File: rtl/q4_gate.sv
// Two-input four-value gate. The Boolean function applied to data is
// chosen by FN. It gives data only when both operands are data, NULL only
// when both are NULL, and Intermediate for every other pair.
// Assumes operands use the q4_pkg encoding; purely combinational.
module q4_gate
    import q4_pkg::*;
#(
    parameter q4_fn_e FN = FN_AND
) (
    input  q4_t op_a,
    input  q4_t op_b,
    output q4_t res
);

    logic both_data;
    logic both_null;
    logic bool_res;

    assign both_data = q4_is_data(op_a) & q4_is_data(op_b);
    assign both_null = q4_is_null(op_a) & q4_is_null(op_b);

    // Select the data-level Boolean function at elaboration
    generate
        if (FN == FN_AND) begin : g_and
            assign bool_res = op_a[0] & op_b[0];
        end else if (FN == FN_OR) begin : g_or
            assign bool_res = op_a[0] | op_b[0];
        end else begin : g_xor
            assign bool_res = op_a[0] ^ op_b[0];
        end
    endgenerate

    // Apply completeness for data and for NULL
    always_comb begin
        if (both_data) begin
            res = {1'b1, bool_res};
        end else if (both_null) begin
            res = Q4_NULL;
        end else begin
            res = Q4_MID;
        end
    end

endmodule

// File: rtl/q4_watch.sv
// Completion detector over WIDTH four-value signals. It reports when all
// of them hold data and when all are NULL. Intermediate values lower both
// flags. Assumes the q4_pkg encoding; purely combinational.
module q4_watch
    import q4_pkg::*;
#(
    parameter int unsigned WIDTH = 6
) (
    input  q4_t [WIDTH-1:0] sig,
    output logic            all_data,
    output logic            all_null
);

    logic [WIDTH-1:0] is_data;
    logic [WIDTH-1:0] is_null;

    // Classify each watched signal
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cls
            assign is_data[i] = q4_is_data(sig[i]);
            assign is_null[i] = q4_is_null(sig[i]);
        end
    endgenerate

    // Reduce the per-signal classes into the two flags
    always_comb begin
        all_data = &is_data;
        all_null = &is_null;
    end

endmodule

// File: rtl/q4_cell_net.sv
// Example network of four-value gates: one gate per Boolean flavour on
// in_a/in_b, a full adder over in_a/in_b/in_c, and a carry gated by in_d.
// A completion detector watches all six results.
// Assumes the inputs move between all-NULL and all-data through
// Intermediate or partial states; purely combinational.
module q4_cell_net
    import q4_pkg::*;
(
    input  logic [1:0] in_a,
    input  logic [1:0] in_b,
    input  logic [1:0] in_c,
    input  logic [1:0] in_d,
    output logic [1:0] out_and,
    output logic [1:0] out_or,
    output logic [1:0] out_xor,
    output logic [1:0] out_sum,
    output logic [1:0] out_carry,
    output logic [1:0] out_gated,
    output logic       set_data,
    output logic       set_null
);

    localparam int unsigned N_RES = 6;

    q4_t half_x;
    q4_t gen_ab;
    q4_t prop_c;
    q4_t res_vec [N_RES];
    q4_t [N_RES-1:0] watch_vec;

    // Direct gate outputs on the first operand pair
    q4_gate #(.FN(FN_AND)) u_and (.op_a(in_a), .op_b(in_b), .res(out_and));
    q4_gate #(.FN(FN_OR))  u_or  (.op_a(in_a), .op_b(in_b), .res(out_or));
    q4_gate #(.FN(FN_XOR)) u_xor (.op_a(in_a), .op_b(in_b), .res(out_xor));

    // Full adder built from the same gate cells
    q4_gate #(.FN(FN_XOR)) u_hx  (.op_a(in_a),   .op_b(in_b),   .res(half_x));
    q4_gate #(.FN(FN_XOR)) u_sum (.op_a(half_x), .op_b(in_c),   .res(out_sum));
    q4_gate #(.FN(FN_AND)) u_gab (.op_a(in_a),   .op_b(in_b),   .res(gen_ab));
    q4_gate #(.FN(FN_AND)) u_pc  (.op_a(half_x), .op_b(in_c),   .res(prop_c));
    q4_gate #(.FN(FN_OR))  u_cy  (.op_a(gen_ab), .op_b(prop_c), .res(out_carry));

    // Carry qualified by the fourth operand
    q4_gate #(.FN(FN_AND)) u_gt  (.op_a(out_carry), .op_b(in_d), .res(out_gated));

    // Gather the results for the completion detector
    always_comb begin
        res_vec[0] = out_and;
        res_vec[1] = out_or;
        res_vec[2] = out_xor;
        res_vec[3] = out_sum;
        res_vec[4] = out_carry;
        res_vec[5] = out_gated;
    end

    generate
        for (genvar k = 0; k < N_RES; k++) begin : g_pack
            assign watch_vec[k] = res_vec[k];
        end
    endgenerate

    q4_watch #(.WIDTH(N_RES)) u_watch (
        .sig      (watch_vec),
        .all_data (set_data),
        .all_null (set_null)
    );

endmodule

// File: rtl/q4_cell_net_chk.sv
// Checker for q4_cell_net: immediate assertions that compare the inputs
// with the gate results and the completion flags. Bound to the top below.
module q4_cell_net_chk (
    input logic [1:0] in_a,
    input logic [1:0] in_b,
    input logic [1:0] in_c,
    input logic [1:0] in_d,
    input logic [1:0] out_and,
    input logic [1:0] out_or,
    input logic [1:0] out_xor,
    input logic [1:0] out_sum,
    input logic [1:0] out_carry,
    input logic [1:0] out_gated,
    input logic       set_data,
    input logic       set_null
);

    // Check the gate and network rules against the inputs
    always_comb begin
        // R1
        if (in_a[1] && in_b[1]) begin
            and_data_chk: assert (out_and == {1'b1, in_a[0] & in_b[0]})
                else $error("and result wrong on data operands");
        end
        // R2
        if (in_a == 2'b00 && in_b == 2'b00) begin
            or_null_chk: assert (out_or == 2'b00)
                else $error("or not NULL on NULL operands");
        end
        // R3
        if ((in_a == 2'b00 && in_b[1]) || (in_b == 2'b00 && in_a[1])) begin
            xor_mix_chk: assert (out_xor == 2'b01)
                else $error("xor not Intermediate on mixed operands");
        end
        // R4
        if (in_c == 2'b01) begin
            sum_mid_chk: assert (out_sum == 2'b01)
                else $error("sum not Intermediate on Intermediate carry-in");
        end
        // R7
        if (in_a[1] || in_b[1] || in_c[1] || in_d[1]) begin
            no_early_null_chk: assert (out_gated != 2'b00 && !set_null)
                else $error("NULL shown while data remains");
        end
        // R8
        if (set_data) begin
            data_flag_chk: assert (out_and[1] && out_or[1] && out_xor[1]
                                   && out_sum[1] && out_carry[1] && out_gated[1])
                else $error("data flag with a non-data result");
        end
        // R8
        flags_excl_chk: assert (!(set_data && set_null))
            else $error("both completion flags high");
    end

endmodule

bind q4_cell_net q4_cell_net_chk u_chk (
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .in_d      (in_d),
    .out_and   (out_and),
    .out_or    (out_or),
    .out_xor   (out_xor),
    .out_sum   (out_sum),
    .out_carry (out_carry),
    .out_gated (out_gated),
    .set_data  (set_data),
    .set_null  (set_null)
);

// File: tb/tb_q4_cell_net.sv
module tb_q4_cell_net;

    localparam logic [1:0] N = 2'b00;
    localparam logic [1:0] M = 2'b01;
    localparam logic [1:0] F = 2'b10;
    localparam logic [1:0] T = 2'b11;

    // {a, b, c, d, sum, carry, gated, set_data, set_null}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {N, N, N, N, N, N, N, 1'b0, 1'b1},
        {F, F, F, F, F, F, F, 1'b1, 1'b0},
        {T, F, T, T, F, T, T, 1'b1, 1'b0},
        {T, T, T, F, T, T, F, 1'b1, 1'b0},
        {F, T, F, T, T, F, F, 1'b1, 1'b0},
        {T, T, F, T, F, T, T, 1'b1, 1'b0},
        {T, T, T, N, T, T, M, 1'b0, 1'b0},
        {N, T, T, T, M, M, M, 1'b0, 1'b0},
        {N, N, T, T, M, M, M, 1'b0, 1'b0},
        {N, N, N, T, N, N, M, 1'b0, 1'b0},
        {M, F, F, F, M, M, M, 1'b0, 1'b0},
        {F, F, T, F, T, F, F, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] in_a = N, in_b = N, in_c = N, in_d = N;
    logic [1:0] out_and, out_or, out_xor, out_sum, out_carry, out_gated;
    logic set_data, set_null;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    q4_cell_net dut (
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .out_and(out_and), .out_or(out_or), .out_xor(out_xor),
        .out_sum(out_sum), .out_carry(out_carry), .out_gated(out_gated),
        .set_data(set_data), .set_null(set_null)
    );

    // Spec-level expected gate result: 0 AND, 1 OR, 2 XOR
    function automatic logic [1:0] gexp(input int fn, input logic [1:0] a, input logic [1:0] b);
        logic v;
        if (a[1] && b[1]) begin
            v = (fn == 0) ? (a[0] & b[0]) : (fn == 1) ? (a[0] | b[0]) : (a[0] ^ b[0]);
            return {1'b1, v};
        end
        if (a == N && b == N) return N;
        return M;
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] a, input logic [1:0] b,
                         input logic [1:0] c, input logic [1:0] d);
        @(posedge clk);
        #1;
        in_a = a; in_b = b; in_c = c; in_d = d;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] seq [4];
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R6 start-up state: all inputs NULL
        drive(N, N, N, N);
        chk("R6 out_sum", out_sum, N);
        chk("R6 out_gated", out_gated, N);
        chk("R6 set_null", {1'b0, set_null}, 2'b01);
        chk("R6 set_data", {1'b0, set_data}, 2'b00);

        // Vector table: R5 adder results, R7/R8 flags
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15:14], VEC[i][13:12], VEC[i][11:10], VEC[i][9:8]);
            chk("R5 out_sum", out_sum, VEC[i][7:6]);
            chk("R5 out_carry", out_carry, VEC[i][5:4]);
            chk("R5 out_gated", out_gated, VEC[i][3:2]);
            chk("R8 set_data", {1'b0, set_data}, {1'b0, VEC[i][1]});
            chk("R8 set_null", {1'b0, set_null}, {1'b0, VEC[i][0]});
        end

        // Exhaustive gate table: R1 data, R2 NULL, R3 mixed, R4 Intermediate
        for (int ia = 0; ia < 4; ia++) begin
            for (int ib = 0; ib < 4; ib++) begin
                drive(2'(ia), 2'(ib), N, N);
                chk("R1-gate and", out_and, gexp(0, 2'(ia), 2'(ib)));
                chk("R1-gate or", out_or, gexp(1, 2'(ia), 2'(ib)));
                chk("R1-gate xor", out_xor, gexp(2, 2'(ia), 2'(ib)));
                if (ia == 0 && ib == 0) chk("R2 and", out_and, N);
                if ((ia == 0 && ib >= 2) || (ib == 0 && ia >= 2)) chk("R3 xor", out_xor, M);
                if (ia == 1 || ib == 1) chk("R4 or", out_or, M);
            end
        end

        // Data wavefront, one input per cycle: R7 no early data
        seq = '{T, T, F, T};
        drive(N, N, N, N);
        drive(seq[0], N, N, N);
        chk("R7 rise gated", {1'b0, out_gated[1]}, 2'b00);
        chk("R7 rise flag", {1'b0, set_data}, 2'b00);
        drive(seq[0], seq[1], N, N);
        chk("R7 rise gated", {1'b0, out_gated[1]}, 2'b00);
        drive(seq[0], seq[1], seq[2], N);
        chk("R7 rise flag", {1'b0, set_data}, 2'b00);
        drive(seq[0], seq[1], seq[2], seq[3]);
        chk("R8 rise done", {1'b0, set_data}, 2'b01);
        chk("R5 rise gated", out_gated, T);

        // NULL wavefront, one input per cycle: R7 no early NULL
        drive(N, seq[1], seq[2], seq[3]);
        chk("R7 fall gated", out_gated, M);
        chk("R7 fall flag", {1'b0, set_null}, 2'b00);
        drive(N, N, seq[2], seq[3]);
        chk("R7 fall gated", out_gated, M);
        drive(N, N, N, seq[3]);
        chk("R7 fall gated", out_gated, M);
        chk("R7 fall flag", {1'b0, set_null}, 2'b00);
        drive(N, N, N, N);
        chk("R6 fall done", {1'b0, set_null}, 2'b01);
        chk("R6 fall gated", out_gated, N);

        // Reverse order release: d first leaves other results data (R7)
        drive(T, T, T, T);
        drive(T, T, T, N);
        chk("R7 d-drop sum", out_sum, T);
        chk("R7 d-drop gated", out_gated, M);
        chk("R8 d-drop flags", {set_data, set_null}, 2'b00);

        finish_run();
    end

endmodule